// File: doc/BRIEF.md
# Scaled Min-Sum Parity-Check Node

This block performs the check-node half of an iterative low-density parity-check decoder using the scaled min-sum rule, for one parity-check row at a time. Variable-to-check messages arrive as signed two's-complement LLRs, one per cycle, under a valid strobe. A last flag marks the final edge of the row. For every edge the block then returns one check-to-variable message. Its magnitude is the smallest magnitude among all the *other* edges of the row, scaled down to about 0.9. Its sign is the parity of the other edges' sign bits.

The block does not store the incoming magnitudes. While the row streams in, it keeps the two smallest magnitudes, the position of the smallest one, a running sign parity and one sign bit per edge. Each leave-one-out result is formed from that compact state as it is emitted. The results leave in the same edge order as the inputs, back to back, beginning the cycle after the row closes. A done flag marks the final result. A row with a single edge is meaningless for a parity check, so such a row is rejected with an error pulse.

Top module: `minsum_check_node`

## Requirements
- R1: After reset, out_valid, out_done and err_single are low and the block is ready to collect a new row.
- R2: For every edge other than the one holding the smallest input magnitude, the output magnitude is the scaled smallest magnitude of the row. Magnitude means the absolute value of the two's-complement input, so -128 has magnitude 128.
- R3: The edge holding the smallest magnitude receives the scaled second-smallest magnitude. When several edges tie for the smallest, the earliest of them counts as the smallest, so every edge receives the tied value.
- R4: An output is negative exactly when an odd number of the other edges have their sign bit (the MSB) set. A zero input counts as non-negative. A zero result is emitted as 0.
- R5: Scaling maps magnitude m to floor(29*m/32), which rounds toward zero. The sign is applied after scaling.
- R6: Results come out in input edge order, one per cycle with no gaps. The first result appears in the cycle after the edge that closes the row is accepted. out_done is high together with out_valid on the final result only.
- R7: A row that closes after a single edge produces no results. Instead, err_single is high for exactly one cycle, the cycle after that edge is accepted, and the block is then ready for the next row.
- R8: In a two-edge row, each edge receives the scaled magnitude of the other edge, with the other edge's sign.
- R9: Input edges offered while results are being emitted are ignored. They change neither the current results nor the next row.
- R10: The MAX_DEG-th accepted edge closes the row even if in_last is low.
- R11: Cycles with in_valid low during collection are skipped without effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An incoming edge message is present |
| in_llr | input | LLR_W | Variable-to-check LLR, two's complement |
| in_last | input | 1 | This edge closes the row |
| out_valid | output | 1 | A check-to-variable result is present |
| out_llr | output | LLR_W | Check-to-variable LLR, two's complement |
| out_done | output | 1 | Final result of the row |
| err_single | output | 1 | One-cycle pulse: the row had only one edge |

## Verification
A wrong smallest-magnitude position shows up within a single row. One edge receives the smallest value instead of the second smallest, which is visible as soon as that edge's result is emitted. A stale sign bit or parity flips the sign of one or all results in the very next row. Stale collection state left over from an ignored input or from a previous row corrupts the first result of the following row. For that reason every scenario is followed directly by a fresh row whose expected values are computed in the bench from its inputs alone.

// File: rtl/mscn_pkg.sv
package mscn_pkg;
    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_EMIT    = 1'b1
    } mscn_state_e;

    // scale factor expressed as SCALE_NUM / 2**SCALE_SHIFT (29/32 ~ 0.906)
    localparam int SCALE_SHIFT = 5;
    localparam int SCALE_NUM   = 29;
endpackage

// File: rtl/mscn_minsort.sv
// Two-smallest tracker: folds one new magnitude into (min1, min2, idx1).
module mscn_minsort #(
    parameter int MAG_W = 8,
    parameter int IDX_W = 4
) (
    input  logic [MAG_W-1:0] min1_i,
    input  logic [MAG_W-1:0] min2_i,
    input  logic [IDX_W-1:0] idx1_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [MAG_W-1:0] min1_o,
    output logic [MAG_W-1:0] min2_o,
    output logic [IDX_W-1:0] idx1_o
);
    always_comb begin
        min1_o = min1_i;
        min2_o = min2_i;
        idx1_o = idx1_i;
        if (mag_i < min1_i) begin
            min2_o = min1_i;
            min1_o = mag_i;
            idx1_o = idx_i;
        end else if (mag_i < min2_i) begin
            min2_o = mag_i;
        end
    end
endmodule

// File: rtl/mscn_scale.sv
// Multiplies a magnitude by 29/32 using shifts and subtracts, truncating.
module mscn_scale #(
    parameter int MAG_W = 8
) (
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W-1:0] mag_o
);
    import mscn_pkg::*;
    localparam int EXT_W = MAG_W + SCALE_SHIFT;

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] acc;

    always_comb begin
        ext   = {{SCALE_SHIFT{1'b0}}, mag_i};
        // 29*m = 32*m - 2*m - m
        acc   = (ext << 5) - (ext << 1) - ext;
        mag_o = acc[EXT_W-1:SCALE_SHIFT];
    end
endmodule

// File: rtl/minsum_check_node.sv
module minsum_check_node #(
    parameter int LLR_W   = 8,
    parameter int MAX_DEG = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LLR_W-1:0] in_llr,
    input  logic             in_last,
    output logic             out_valid,
    output logic [LLR_W-1:0] out_llr,
    output logic             out_done,
    output logic             err_single
);
    import mscn_pkg::*;

    localparam int IDX_W = (MAX_DEG > 2) ? $clog2(MAX_DEG) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_DEG - 1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
    localparam logic [LLR_W-1:0] MAG_MAX = '1;

    typedef struct packed {
        mscn_state_e        st;
        logic [IDX_W-1:0]   cnt;
        logic [IDX_W-1:0]   last_idx;
        logic [LLR_W-1:0]   min1;
        logic [LLR_W-1:0]   min2;
        logic [IDX_W-1:0]   idx1;
        logic               par;
        logic [MAX_DEG-1:0] signs;
        logic               err;
    } regs_t;

    regs_t r_q, r_d;

    logic             in_sign;
    logic [LLR_W-1:0] in_mag;
    logic [LLR_W-1:0] ms_min1, ms_min2;
    logic [IDX_W-1:0] ms_idx1;
    logic [LLR_W-1:0] sel_mag;
    logic [LLR_W-1:0] scaled_mag;
    logic             out_sign;

    always_comb begin
        in_sign = in_llr[LLR_W-1];
        in_mag  = in_sign ? (~in_llr + LLR_W'(1)) : in_llr;
    end

    mscn_minsort #(.MAG_W(LLR_W), .IDX_W(IDX_W)) u_minsort (
        .min1_i (r_q.min1),
        .min2_i (r_q.min2),
        .idx1_i (r_q.idx1),
        .mag_i  (in_mag),
        .idx_i  (r_q.cnt),
        .min1_o (ms_min1),
        .min2_o (ms_min2),
        .idx1_o (ms_idx1)
    );

    always_comb begin
        sel_mag  = (r_q.cnt == r_q.idx1) ? r_q.min2 : r_q.min1;
        out_sign = r_q.par ^ r_q.signs[r_q.cnt];
    end

    mscn_scale #(.MAG_W(LLR_W)) u_scale (
        .mag_i (sel_mag),
        .mag_o (scaled_mag)
    );

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        case (r_q.st)
            ST_COLLECT: begin
                if (in_valid) begin
                    r_d.min1             = ms_min1;
                    r_d.min2             = ms_min2;
                    r_d.idx1             = ms_idx1;
                    r_d.par              = r_q.par ^ in_sign;
                    r_d.signs[r_q.cnt]   = in_sign;
                    if (in_last || (r_q.cnt == IDX_TOP)) begin
                        if (r_q.cnt == '0) begin
                            r_d.err   = 1'b1;
                            r_d.min1  = MAG_MAX;
                            r_d.min2  = MAG_MAX;
                            r_d.idx1  = '0;
                            r_d.par   = 1'b0;
                            r_d.signs = '0;
                        end else begin
                            r_d.st       = ST_EMIT;
                            r_d.last_idx = r_q.cnt;
                            r_d.cnt      = '0;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + IDX_ONE;
                    end
                end
            end
            default: begin
                if (r_q.cnt == r_q.last_idx) begin
                    r_d.st    = ST_COLLECT;
                    r_d.cnt   = '0;
                    r_d.min1  = MAG_MAX;
                    r_d.min2  = MAG_MAX;
                    r_d.idx1  = '0;
                    r_d.par   = 1'b0;
                    r_d.signs = '0;
                end else begin
                    r_d.cnt = r_q.cnt + IDX_ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_COLLECT;
            r_q.cnt      <= '0;
            r_q.last_idx <= '0;
            r_q.min1     <= MAG_MAX;
            r_q.min2     <= MAG_MAX;
            r_q.idx1     <= '0;
            r_q.par      <= 1'b0;
            r_q.signs    <= '0;
            r_q.err      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        out_valid  = (r_q.st == ST_EMIT);
        out_done   = out_valid && (r_q.cnt == r_q.last_idx);
        out_llr    = out_sign ? (~scaled_mag + LLR_W'(1)) : scaled_mag;
        err_single = r_q.err;
    end
endmodule

// File: rtl/mscn_checker.sv
module mscn_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_last,
    input logic out_valid,
    input logic out_done,
    input logic err_single
);
    // R6: done only accompanies a valid result
    p_done_has_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid);

    // R6: emission is gapless until done
    p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_done) |=> out_valid);

    // R6: emission stops after done
    p_stop_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_valid);

    // R7: an error pulse lasts one cycle and never overlaps results
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_single |=> !err_single);

    p_err_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && out_valid));

    // R7: an error follows an accepted input edge
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_single) |-> $past(in_valid));

    // R6: emission starts only after an accepted edge
    p_start_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));

    // R1: quiet right after reset release
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && !err_single));

    logic unused_last;
    assign unused_last = in_last;
endmodule

bind minsum_check_node mscn_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_done   (out_done),
    .err_single (err_single)
);

// File: tb/sim_minsum_check_node.sv
module sim_minsum_check_node;
    localparam int W   = 8;
    localparam int DEG = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_llr = '0;
    logic         in_last = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_llr;
    logic         out_done;
    logic         err_single;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    llr;
        bit    done;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   v[$];

    always #2 clk = ~clk;

    minsum_check_node #(.LLR_W(W), .MAX_DEG(DEG)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
        .in_last(in_last), .out_valid(out_valid), .out_llr(out_llr),
        .out_done(out_done), .err_single(err_single)
    );

    function automatic int mag_of(int x);
        return (x < 0) ? -x : x;
    endfunction

    // leave-one-out reference: min over others, parity of others, 29/32 truncation
    function automatic int ref_out(int k);
        int minm = 1000;
        bit par = 1'b0;
        int sc;
        for (int j = 0; j < v.size(); j++) begin
            if (j != k) begin
                if (mag_of(v[j]) < minm) minm = mag_of(v[j]);
                par ^= (v[j] < 0);
            end
        end
        sc = (minm * 29) / 32;
        return par ? -sc : sc;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every emitted result
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected result", $signed(out_llr), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check($signed(out_llr) == e.llr, e.tag, $signed(out_llr), e.llr);
                check(out_done == e.done, "R6 done flag", int'(out_done), int'(e.done));
            end
        end
    end

    task automatic send(int gap, bit with_last, bit noise, string tag);
        int n = v.size();
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_llr   = v[k][W-1:0];
            in_last  = with_last && (k == n - 1);
            if (k == n - 1) begin
                for (int j = 0; j < n; j++) begin
                    exp_t e;
                    e.llr  = ref_out(j);
                    e.done = (j == n - 1);
                    e.tag  = tag;
                    sb.push_back(e);
                end
            end else if (gap > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(out_valid == 1'b1, "R6 first result timing", int'(out_valid), 1);
        while (out_valid) begin
            if (noise) begin
                in_valid = 1'b1;      // R9: offered during emission
                in_llr   = 8'h81;
                in_last  = 1'b1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(sb.size() == 0, "R6 result count", sb.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(err_single == 1'b0, "R1 err_single", int'(err_single), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_done == 1'b0, "R1 idle after release", int'(out_valid), 0);

        // R2 R3 R4 R5: mixed row
        v = '{10, -20, 5, 30, -7};
        send(0, 1'b1, 1'b0, "R2 R3 R4 mixed row");
        // R8: two edges
        v = '{-50, 40};
        send(0, 1'b1, 1'b0, "R8 two edges");
        // R3: tie on the smallest, all negative
        v = '{-12, -12, -40, -12};
        send(0, 1'b1, 1'b0, "R3 tied minimum");
        // R4 R5: zero and extreme values
        v = '{0, -128, 127, 3};
        send(0, 1'b1, 1'b0, "R4 R5 zero and extremes");
        v = '{-128, 127, -100};
        send(0, 1'b1, 1'b0, "R5 large magnitudes");
        // R11: gaps during collection
        v = '{33, -9, 14, 60, -2, 8};
        send(2, 1'b1, 1'b0, "R11 gapped row");
        // R9: noise while emitting, then a clean row
        v = '{25, -35, 45};
        send(0, 1'b1, 1'b1, "R9 row with noise");
        v = '{-6, 11, 19};
        send(0, 1'b1, 1'b0, "R9 next row unaffected");

        // R7: single-edge row
        @(negedge clk);
        in_valid = 1'b1; in_llr = 8'd42; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check(err_single == 1'b1, "R7 error pulse", int'(err_single), 1);
        check(out_valid == 1'b0, "R7 no result", int'(out_valid), 0);
        @(negedge clk);
        check(err_single == 1'b0, "R7 pulse width", int'(err_single), 0);
        check(out_valid == 1'b0, "R7 still no result", int'(out_valid), 0);
        v = '{-3, 70, -90};
        send(0, 1'b1, 1'b0, "R7 recovery row");

        // R10: full-degree row with no last flag
        v = {};
        for (int k = 0; k < DEG; k++) v.push_back((k % 3 == 0) ? -(20 + k) : (15 + 2 * k));
        send(0, 1'b0, 1'b0, "R10 full degree row");
        v = '{9, -4};
        send(0, 1'b1, 1'b0, "R10 row after full degree");

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule